// File: doc/BRIEF.md
# Auto-Incrementing Lookup-Table SRAM Loader

This block sits between a simple 16-bit register port and an external synchronous SRAM that holds a lookup table. Software fills or checks the table through four register selectors. It first loads the upper address bits and then the lower 16 address bits. After that it streams data words. Each data-word access makes exactly one SRAM cycle at the current address. The shared address counter then steps by one, so a long table can be written or read back without reloading the address.

In the default two-half build the SRAM is 32 bits wide and is treated as two independent 16-bit tables that share the one counter. Each half has its own active-low write enable, so writing one half never disturbs the other. A single-half build (`HALVES = 1`) drives a 16-bit SRAM and ignores the high-half selector. The address width is a parameter: 19 bits by default, and 18 bits suits a smaller table. All SRAM strobes are active low and registered.

Register selector encoding on `bus_sel`: 0 = upper address, 1 = lower address, 2 = low-half data, 3 = high-half data.

Top module: `lut_loader`

## Requirements
- R1: After reset the SRAM chip, output and both write enables are high, `bus_busy` and `bus_rvalid` are low, and the address counter is zero.
- R2: A write to selector 0 loads counter bits ADDR_W-1..16 from the low bits of `bus_wdata` and leaves bits 15..0 unchanged. A write to selector 1 loads bits 15..0 and leaves the upper bits unchanged. A read of selector 0 returns the upper bits zero-extended, and a read of selector 1 returns bits 15..0. For both reads `bus_rvalid` pulses in the cycle after the accepting edge.
- R3: A data write (selector 2 or 3 with `bus_wr`=1) drives `sram_ce_n` and the matching write enable low for exactly the one cycle after the accepting edge. In that cycle `sram_oe_n` stays high, `sram_addr` equals the counter, and every 16-bit lane of `sram_wdata` carries the word.
- R4: Selector 2 strobes only `sram_we_lo_n` (bits 15..0) and selector 3 strobes only `sram_we_hi_n` (bits 31..16). The two are never low together, so the other half of the word keeps its contents.
- R5: Each data write advances the counter by exactly one once the write strobe has been issued.
- R6: A data read drives `sram_ce_n` and `sram_oe_n` low, with both write enables high, for the one cycle after the accepting edge. The SRAM returns data one cycle after it samples the strobe. `bus_rvalid` then pulses for one cycle, two cycles after the strobe cycle, carrying the selected half.
- R7: Each data read advances the counter by exactly one, on the edge that captures the read data. `bus_busy` is high for two cycles per read and for one cycle per write.
- R8: Stepping from the highest address (all ADDR_W bits set) gives address zero.
- R9: A request presented while `bus_busy` is high is ignored. The SRAM is strobed only while `bus_busy` is high.
- R10: With `HALVES = 1`, a selector-3 access is ignored: no strobe, no `bus_rvalid`, and the counter is unchanged. `sram_we_hi_n` stays high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access request, taken on a clock edge while not busy |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 2 | Register selector (0 upper addr, 1 lower addr, 2 low data, 3 high data) |
| bus_wdata | input | 16 | Write data |
| bus_busy | output | 1 | An SRAM access is in progress |
| bus_rvalid | output | 1 | One-cycle pulse marking valid `bus_rdata` |
| bus_rdata | output | 16 | Read data |
| sram_addr | output | ADDR_W | SRAM address |
| sram_wdata | output | 16*HALVES | SRAM write data |
| sram_rdata | input | 16*HALVES | SRAM read data |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_lo_n | output | 1 | Write enable for bits 15..0, active low |
| sram_we_hi_n | output | 1 | Write enable for bits 31..16, active low |

## Verification
The properties watch the SRAM pins on every cycle. They check that the two write enables are never low together, that every strobe lasts one cycle and appears only while busy, and that a write strobe never coincides with an output enable. They also check that the counter steps by one after each write strobe and after each read capture, and that a read strobe is followed two cycles later by `bus_rvalid`. What the properties cannot see is the value side. That includes the split of upper and lower address loads, the readback values, the independence of the two halves held in the SRAM model, wrap at the top address, the dropping of requests made while busy, and the single-half build's treatment of selector 3. The bench's scenarios show those.

// File: rtl/lut_ldr_pkg.sv
package lut_ldr_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR_HI = 2'd0,
    SEL_ADDR_LO = 2'd1,
    SEL_DATA_LO = 2'd2,
    SEL_DATA_HI = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WR       = 2'd1,
    ST_RD_ISSUE = 2'd2,
    ST_RD_WAIT  = 2'd3
  } st_e;

  // Next table address, modulo 2**w (w <= 31).
  function automatic logic [31:0] addr_step(input logic [31:0] a, input int unsigned w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return (a + 32'd1) & mask;
  endfunction

  // Upper address field zero-extended to a 16-bit register view.
  function automatic logic [15:0] upper_view(input logic [31:0] a, input int unsigned w);
    return 16'((a & ((32'd1 << w) - 32'd1)) >> 16);
  endfunction

endpackage

// File: rtl/lut_ldr_addr_ctr.sv
module lut_ldr_addr_ctr
  import lut_ldr_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic [15:0]       wdata,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  localparam int HI_W = ADDR_W - 16;

  logic [HI_W-1:0] hi_part;
  assign hi_part = HI_W'(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (ld_hi) begin
      addr[ADDR_W-1:16] <= hi_part;
    end else if (ld_lo) begin
      addr[15:0] <= wdata;
    end else if (step) begin
      addr <= ADDR_W'(addr_step(32'(addr), ADDR_W));
    end
  end

endmodule

// File: rtl/lut_ldr_seq.sv
module lut_ldr_seq
  import lut_ldr_pkg::*;
#(
  parameter int HALVES = 2,
  parameter int ADDR_W = 19,
  localparam int DW = 16 * HALVES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_wr,
  input  logic              go_hi,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [15:0]       wdata_in,
  output logic              busy,
  output logic              step,
  output logic              cap,
  output logic              cap_hi,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DW-1:0]     sram_wdata,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_lo_n,
  output logic              sram_we_hi_n
);
  st_e  st_q;
  logic half_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      sram_ce_n    <= 1'b1;
      sram_oe_n    <= 1'b1;
      sram_we_lo_n <= 1'b1;
      sram_addr    <= '0;
      sram_wdata   <= '0;
      half_q       <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (go) begin
            st_q         <= go_wr ? ST_WR : ST_RD_ISSUE;
            sram_ce_n    <= 1'b0;
            sram_oe_n    <= go_wr;
            sram_we_lo_n <= !(go_wr && !go_hi);
            sram_addr    <= addr_in;
            sram_wdata   <= {HALVES{wdata_in}};
            half_q       <= go_hi;
          end
        end
        ST_WR: begin
          st_q         <= ST_IDLE;
          sram_ce_n    <= 1'b1;
          sram_we_lo_n <= 1'b1;
        end
        ST_RD_ISSUE: begin
          st_q      <= ST_RD_WAIT;
          sram_ce_n <= 1'b1;
          sram_oe_n <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  generate
    if (HALVES == 2) begin : g_two_halves
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sram_we_hi_n <= 1'b1;
        end else if (st_q == ST_IDLE && go) begin
          sram_we_hi_n <= !(go_wr && go_hi);
        end else if (st_q == ST_WR) begin
          sram_we_hi_n <= 1'b1;
        end
      end
    end else begin : g_one_half
      assign sram_we_hi_n = 1'b1;
    end
  endgenerate

  assign busy   = (st_q != ST_IDLE);
  assign step   = (st_q == ST_WR) || (st_q == ST_RD_WAIT);
  assign cap    = (st_q == ST_RD_WAIT);
  assign cap_hi = half_q;

endmodule

// File: rtl/lut_ldr_rdport.sv
module lut_ldr_rdport
  import lut_ldr_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cap,
  input  logic              cap_hi,
  input  logic [DW-1:0]     sram_rdata,
  output logic              rvalid,
  output logic [15:0]       rdata
);
  logic [15:0] reg_view;
  logic [15:0] half_view;

  assign reg_view  = reg_hi ? upper_view(32'(addr), ADDR_W) : addr[15:0];
  assign half_view = cap_hi ? sram_rdata[DW-1 -: 16] : sram_rdata[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= reg_rd || cap;
      if (reg_rd) begin
        rdata <= reg_view;
      end else if (cap) begin
        rdata <= half_view;
      end
    end
  end

endmodule

// File: rtl/lut_loader.sv
module lut_loader
  import lut_ldr_pkg::*;
#(
  parameter int HALVES = 2,
  parameter int ADDR_W = 19,
  localparam int DW = 16 * HALVES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [1:0]        bus_sel,
  input  logic [15:0]       bus_wdata,
  output logic              bus_busy,
  output logic              bus_rvalid,
  output logic [15:0]       bus_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DW-1:0]     sram_wdata,
  input  logic [DW-1:0]     sram_rdata,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_lo_n,
  output logic              sram_we_hi_n
);
  localparam bit HAS_HI = (HALVES == 2);

  sel_e              sel;
  logic              accept;
  logic              is_data;
  logic              data_go;
  logic              ld_hi;
  logic              ld_lo;
  logic              reg_rd;
  logic              step;
  logic              cap;
  logic              cap_hi;
  logic [ADDR_W-1:0] addr_q;

  assign sel     = sel_e'(bus_sel);
  assign accept  = bus_en && !bus_busy;
  assign is_data = (sel == SEL_DATA_LO) || (HAS_HI && sel == SEL_DATA_HI);
  assign data_go = accept && is_data;
  assign ld_hi   = accept && bus_wr && (sel == SEL_ADDR_HI);
  assign ld_lo   = accept && bus_wr && (sel == SEL_ADDR_LO);
  assign reg_rd  = accept && !bus_wr && !bus_sel[1];

  lut_ldr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_hi (ld_hi),
    .ld_lo (ld_lo),
    .wdata (bus_wdata),
    .step  (step),
    .addr  (addr_q)
  );

  lut_ldr_seq #(.HALVES(HALVES), .ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (data_go),
    .go_wr        (bus_wr),
    .go_hi        (sel == SEL_DATA_HI),
    .addr_in      (addr_q),
    .wdata_in     (bus_wdata),
    .busy         (bus_busy),
    .step         (step),
    .cap          (cap),
    .cap_hi       (cap_hi),
    .sram_addr    (sram_addr),
    .sram_wdata   (sram_wdata),
    .sram_ce_n    (sram_ce_n),
    .sram_oe_n    (sram_oe_n),
    .sram_we_lo_n (sram_we_lo_n),
    .sram_we_hi_n (sram_we_hi_n)
  );

  lut_ldr_rdport #(.ADDR_W(ADDR_W), .DW(DW)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd     (reg_rd),
    .reg_hi     (sel == SEL_ADDR_HI),
    .addr       (addr_q),
    .cap        (cap),
    .cap_hi     (cap_hi),
    .sram_rdata (sram_rdata),
    .rvalid     (bus_rvalid),
    .rdata      (bus_rdata)
  );

endmodule

// File: rtl/lut_loader_chk.sv
module lut_loader_chk #(
  parameter int HALVES = 2,
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_busy,
  input logic              bus_rvalid,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_lo_n,
  input logic              sram_we_hi_n,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [ADDR_W-1:0] addr_q
);
  logic wr_strobe;
  logic rd_strobe;
  assign wr_strobe = !sram_ce_n && (!sram_we_lo_n || !sram_we_hi_n);
  assign rd_strobe = !sram_ce_n && !sram_oe_n;

  p_we_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_lo_n && !sram_we_hi_n));

  p_we_with_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_lo_n || !sram_we_hi_n) |-> (!sram_ce_n && sram_oe_n));

  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |=> sram_ce_n);

  p_write_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> (addr_q == $past(sram_addr) + ADDR_W'(1)));

  p_read_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> ##1 (addr_q == $past(sram_addr, 2) + ADDR_W'(1)));

  p_rvalid_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> ##1 bus_rvalid);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |-> sram_ce_n);

  p_narrow_hi_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (HALVES == 1) |-> sram_we_hi_n);

endmodule

bind lut_loader lut_loader_chk #(.HALVES(HALVES), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_busy     (bus_busy),
  .bus_rvalid   (bus_rvalid),
  .sram_ce_n    (sram_ce_n),
  .sram_oe_n    (sram_oe_n),
  .sram_we_lo_n (sram_we_lo_n),
  .sram_we_hi_n (sram_we_hi_n),
  .sram_addr    (sram_addr),
  .addr_q       (addr_q)
);

// File: tb/lut_loader_tb.sv
module lut_loader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        en0 = 1'b0, en1 = 1'b0, wr = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [15:0] wd = 16'h0;

  logic        busy0, rv0, ce0, oe0, wl0, wh0;
  logic [15:0] rd0;
  logic [18:0] a0;
  logic [31:0] w0;
  logic [31:0] q0 = 32'h0;
  logic        busy1, rv1, ce1, oe1, wl1, wh1;
  logic [15:0] rd1;
  logic [17:0] a1;
  logic [15:0] w1;
  logic [15:0] q1 = 16'h0;

  lut_loader #(.HALVES(2), .ADDR_W(19)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(en0), .bus_wr(wr), .bus_sel(sel), .bus_wdata(wd),
    .bus_busy(busy0), .bus_rvalid(rv0), .bus_rdata(rd0), .sram_addr(a0), .sram_wdata(w0),
    .sram_rdata(q0), .sram_ce_n(ce0), .sram_oe_n(oe0), .sram_we_lo_n(wl0), .sram_we_hi_n(wh0));

  lut_loader #(.HALVES(1), .ADDR_W(18)) u_dut_narrow (
    .clk(clk), .rst_n(rst_n), .bus_en(en1), .bus_wr(wr), .bus_sel(sel), .bus_wdata(wd),
    .bus_busy(busy1), .bus_rvalid(rv1), .bus_rdata(rd1), .sram_addr(a1), .sram_wdata(w1),
    .sram_rdata(q1), .sram_ce_n(ce1), .sram_oe_n(oe1), .sram_we_lo_n(wl1), .sram_we_hi_n(wh1));

  // Synchronous SRAM models, one-cycle read latency.
  logic [31:0] mem0 [logic [18:0]];
  logic [15:0] mem1 [logic [17:0]];
  logic [31:0] c0;

  always @(posedge clk) begin
    if (!ce0 && !oe0) q0 <= mem0.exists(a0) ? mem0[a0] : 32'h0;
    if (!ce0 && (!wl0 || !wh0)) begin
      c0 = mem0.exists(a0) ? mem0[a0] : 32'h0;
      if (!wl0) c0[15:0]  = w0[15:0];
      if (!wh0) c0[31:16] = w0[31:16];
      mem0[a0] = c0;
    end
    if (!ce1 && !oe1) q1 <= mem1.exists(a1) ? mem1[a1] : 16'h0;
    if (!ce1 && !wl1) mem1[a1] = w1;
  end

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input bit n, input logic [1:0] s, input bit w, input logic [15:0] d,
                    output logic [15:0] r, output bit got);
    got = 1'b0;
    r = 16'h0;
    while (n ? busy1 : busy0) @(negedge clk);
    sel = s; wr = w; wd = d;
    if (n) en1 = 1'b1; else en0 = 1'b1;
    @(negedge clk);
    en0 = 1'b0; en1 = 1'b0;
    if (!w) begin
      for (int k = 0; k < 4; k++) begin
        if (!got) begin
          if (n ? rv1 : rv0) begin
            got = 1'b1;
            r = n ? rd1 : rd0;
          end else begin
            @(negedge clk);
          end
        end
      end
    end
    while (n ? busy1 : busy0) @(negedge clk);
  endtask

  task automatic wreg(input bit n, input logic [1:0] s, input logic [15:0] d);
    logic [15:0] r;
    bit g;
    op(n, s, 1'b1, d, r, g);
  endtask

  task automatic rreg(input bit n, input logic [1:0] s, output logic [15:0] r);
    bit g;
    op(n, s, 1'b0, 16'h0, r, g);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  // {sel[1:0], wr, wdata[15:0], expected read data[15:0]}
  localparam logic [34:0] VEC [15] = '{
    {2'd0, 1'b1, 16'h0005, 16'h0000},
    {2'd1, 1'b1, 16'h1230, 16'h0000},
    {2'd0, 1'b0, 16'h0000, 16'h0005},
    {2'd1, 1'b0, 16'h0000, 16'h1230},
    {2'd2, 1'b1, 16'hA001, 16'h0000},
    {2'd2, 1'b1, 16'hA002, 16'h0000},
    {2'd1, 1'b1, 16'h1230, 16'h0000},
    {2'd3, 1'b1, 16'hB001, 16'h0000},
    {2'd1, 1'b1, 16'h1230, 16'h0000},
    {2'd2, 1'b0, 16'h0000, 16'hA001},
    {2'd1, 1'b1, 16'h1230, 16'h0000},
    {2'd3, 1'b0, 16'h0000, 16'hB001},
    {2'd2, 1'b0, 16'h0000, 16'hA002},
    {2'd1, 1'b0, 16'h0000, 16'h1232},
    {2'd0, 1'b0, 16'h0000, 16'h0005}
  };

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    bit g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 strobes", {28'h0, ce0, oe0, wl0, wh0}, 32'hF);
    check("R1 busy/rvalid", {30'h0, busy0, rv0}, 32'h0);
    check("R1 narrow strobes", {28'h0, ce1, oe1, wl1, wh1}, 32'hF);
    rreg(1'b0, 2'd1, r); check("R1 counter low", {16'h0, r}, 32'h0);
    rreg(1'b0, 2'd0, r); check("R1 counter high", {16'h0, r}, 32'h0);

    // Vector walk: R2 address loads, R4 half independence, R5/R7 stepping, R6 reads
    for (int i = 0; i < 15; i++) begin
      op(1'b0, VEC[i][34:33], VEC[i][32], VEC[i][31:16], r, g);
      if (!VEC[i][32]) begin
        check(VEC[i][34] ? "R6/R4 data read" : "R2/R5 address read", {15'h0, g, r}, {16'h1, VEC[i][15:0]});
      end
    end

    // R8 wrap from top address
    wreg(1'b0, 2'd0, 16'h0007);
    wreg(1'b0, 2'd1, 16'hFFFF);
    wreg(1'b0, 2'd2, 16'h1234);
    rreg(1'b0, 2'd0, r); check("R8 wrap high", {16'h0, r}, 32'h0);
    rreg(1'b0, 2'd1, r); check("R8 wrap low", {16'h0, r}, 32'h0);
    wreg(1'b0, 2'd0, 16'h0007);
    wreg(1'b0, 2'd1, 16'hFFFF);
    rreg(1'b0, 2'd2, r); check("R8 top word readback", {16'h0, r}, 32'h1234);

    // R3 write strobe timing, R9 request during busy ignored
    wreg(1'b0, 2'd0, 16'h0000);
    wreg(1'b0, 2'd1, 16'h0100);
    sel = 2'd2; wr = 1'b1; wd = 16'h5555; en0 = 1'b1;
    @(negedge clk);
    check("R3 write pins", {27'h0, busy0, ce0, oe0, wl0, wh0}, {27'h0, 5'b10101});
    check("R3 write addr", {13'h0, a0}, 32'h00100);
    check("R3 write data", w0, 32'h55555555);
    sel = 2'd1; wd = 16'h7777;
    @(negedge clk);
    en0 = 1'b0;
    check("R3 strobe released", {30'h0, busy0, ce0}, 32'h1);
    rreg(1'b0, 2'd1, r); check("R9 busy request ignored", {16'h0, r}, 32'h0101);

    // R6 read timing, R7 step after capture
    wreg(1'b0, 2'd1, 16'h0100);
    sel = 2'd2; wr = 1'b0; en0 = 1'b1;
    @(negedge clk);
    en0 = 1'b0;
    check("R6 read strobe", {26'h0, busy0, rv0, ce0, oe0, wl0, wh0}, {26'h0, 6'b100011});
    @(negedge clk);
    check("R6 wait cycle", {29'h0, busy0, rv0, ce0}, {29'h0, 3'b101});
    @(negedge clk);
    check("R6 rvalid data", {15'h0, rv0, rd0}, {16'h1, 16'h5555});
    @(negedge clk);
    check("R6 rvalid single", {31'h0, rv0}, 32'h0);
    rreg(1'b0, 2'd1, r); check("R7 step after read", {16'h0, r}, 32'h0101);

    // R10 single-half build
    wreg(1'b1, 2'd0, 16'hFFFF);
    rreg(1'b1, 2'd0, r); check("R10 narrow upper width", {16'h0, r}, 32'h0003);
    wreg(1'b1, 2'd1, 16'h0010);
    sel = 2'd3; wr = 1'b1; wd = 16'h9999; en1 = 1'b1;
    @(negedge clk);
    en1 = 1'b0;
    check("R10 high select ignored", {29'h0, busy1, ce1, wh1}, {29'h0, 3'b011});
    rreg(1'b1, 2'd1, r); check("R10 counter unchanged", {16'h0, r}, 32'h0010);
    op(1'b1, 2'd3, 1'b0, 16'h0, r, g); check("R10 high read no rvalid", {31'h0, g}, 32'h0);
    wreg(1'b1, 2'd2, 16'h4242);
    wreg(1'b1, 2'd1, 16'h0010);
    rreg(1'b1, 2'd2, r); check("R10 low half readback", {16'h0, r}, 32'h4242);

    finish_run();
  end

endmodule